// File: doc/BRIEF.md
# NAND command and address cycle generator

This block drives the chip enable, command latch, address latch, write-protect and 8-bit I/O lines of a small-page NAND flash during command and address phases. A single request carries either one command byte or an address of one, two or three cycles taken from a 24-bit byte offset. The block raises chip enable together with the matching latch enable. It holds that latch for a fixed settle time, then strobes out each I/O byte for one cycle. After the last byte it issues one pipeline-terminate strobe and lowers the latch while chip enable stays high. A second fixed settle time follows, and then the block reports done.

Address bytes never carry offset bit 8. In the two-byte form, used for block erase, the low byte is dropped as well. The write-protect flag of the request is carried on the write-protect line for the whole phase. An address request may carry an extra protect flag, which joins in only after the address latch has fallen. A request with an address-cycle count of zero is refused: the block pulses an error output and leaves the flash bus untouched. Data transfer, error correction and the ready/busy wait belong to other blocks.

Top module: `nand_cmd_addr_gen`

## Requirements
- R1: For a command request (req_is_addr=0) the outputs follow this order. nand_ce and nand_cle are high for 4 cycles with no strobe. The next cycle carries one io_we strobe with io_data equal to the command byte. The cycle after that is the terminate strobe. Then come 4 cycles with only nand_ce high, and then one done cycle.
- R2: nand_cle and nand_ale are never high together. nand_ale is high only for address requests and nand_cle only for command requests, and either latch is high only while nand_ce is high.
- R3: Each I/O byte is valid for exactly one cycle with io_we high. Before the first byte the latch enable has been high for 4 cycles.
- R4: An address request with req_ncyc=1 sends one byte, offset bits 7:0.
- R5: An address request with req_ncyc=2 sends offset bits 16:9 and then offset bits 23:17 zero-extended to 8 bits.
- R6: An address request with req_ncyc=3 sends bits 7:0, then bits 16:9, then bits 23:17 zero-extended. Offset bit 8 never reaches the bus.
- R7: pipe_term is high for exactly one cycle, directly after the last io_we strobe, with the latch enable still high. The latch enable is low in the following cycle.
- R8: nand_wp equals req_wp from the first cycle of the phase until the latch falls. During the trailing 4 cycles nand_wp equals req_wp OR req_tail_wp for address requests, and req_wp alone for command requests.
- R9: An address request with req_ncyc=0 produces a one-cycle err pulse (with busy high). No nand_ce, nand_cle, nand_ale, io_we, pipe_term or done follows it.
- R10: A request is taken only while busy is low. busy stays high from the cycle after acceptance through the one-cycle done pulse. A request presented while busy is ignored.
- R11: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_is_addr | input | 1 | 1: address phase, 0: command phase |
| req_cmd | input | 8 | Command byte |
| req_ncyc | input | 2 | Address cycle count (1 to 3) |
| req_offset | input | 24 | Byte offset for address cycles |
| req_wp | input | 1 | Write-protect flag for the whole phase |
| req_tail_wp | input | 1 | Extra protect flag applied after the address latch falls |
| nand_ce | output | 1 | Chip enable (active high) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wp | output | 1 | Write-protect control |
| io_data | output | 8 | I/O bus byte |
| io_we | output | 1 | I/O byte write strobe |
| pipe_term | output | 1 | Pipeline-terminate strobe |
| busy | output | 1 | Phase in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
Assertions guard the line relationships that must hold in every cycle. The two latch enables are exclusive and depend on chip enable. A byte strobe always follows a cycle with the latch high. The terminate strobe is single and comes right after a strobe. A rejected request never touches the bus, and done is followed by idle. The exact settle lengths, the byte order for each cycle count, the skipped offset bit 8, the late joining of the extra protect flag, and the ignoring of requests while busy can only be shown by the bench. It compares every output cycle by cycle against a trace built from the request.

// File: rtl/nand_cag_pkg.sv
// Shared state encoding for the NAND command/address cycle generator.
// Assumes: one phase in flight at a time.
package nand_cag_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_BYTE  = 3'd2,
        ST_TERM  = 3'd3,
        ST_TRAIL = 3'd4,
        ST_DONE  = 3'd5,
        ST_ERR   = 3'd6
    } cag_state_e;
endpackage

// File: rtl/nand_cag_timer.sv
// Cycle counter shared by the settle windows and the byte index.
// Assumes: clr is asserted on every state change by the sequencer.
module nand_cag_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // Count up, restart from zero on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/nand_cag_byte_sel.sv
// Picks the I/O byte for a given byte index.
// Address bytes are low (bits DATA_W-1:0), mid (bits 2*DATA_W:DATA_W+1),
// high (bits OFS_W-1:2*DATA_W+1, zero-extended). Bit DATA_W is never sent.
// Assumes: 0 < OFS_W-2*DATA_W-1 <= DATA_W; ncyc is 1..3 for address phases.
module nand_cag_byte_sel #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 24
) (
    input  logic              is_addr,
    input  logic [DATA_W-1:0] cmd,
    input  logic [1:0]        ncyc,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [1:0]        idx,
    output logic [DATA_W-1:0] byte_o
);
    localparam int HI_W = OFS_W - 2*DATA_W - 1;

    logic [DATA_W-1:0] b_low, b_mid, b_high;
    logic [1:0]        pos;

    assign b_low = ofs[DATA_W-1:0];
    assign b_mid = ofs[2*DATA_W:DATA_W+1];

    generate
        if (HI_W == DATA_W) begin : g_hi_full
            assign b_high = ofs[OFS_W-1 -: HI_W];
        end else begin : g_hi_pad
            assign b_high = {{(DATA_W-HI_W){1'b0}}, ofs[OFS_W-1 -: HI_W]};
        end
    endgenerate

    // Two-cycle addresses start at the mid byte; others start at the low byte.
    always_comb begin
        pos = idx + ((ncyc == 2'd2) ? 2'd1 : 2'd0);
        if (!is_addr)         byte_o = cmd;
        else if (pos == 2'd0) byte_o = b_low;
        else if (pos == 2'd1) byte_o = b_mid;
        else                  byte_o = b_high;
    end
endmodule

// File: rtl/nand_cag_seq.sv
// Phase sequencer: lead settle, byte strobes, terminate, trail settle, done.
// Assumes: start only while idle; nbytes is 1..3 whenever bad is low.
module nand_cag_seq
    import nand_cag_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bad,
    input  logic [1:0]       nbytes,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output cag_state_e       state
);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    cag_state_e st_nx;
    logic [CNT_W-1:0] byte_last;

    assign byte_last = CNT_W'(nbytes) - 1'b1;

    // Next-state decision from the current state and the shared counter.
    always_comb begin
        st_nx = state;
        case (state)
            ST_IDLE:  if (start) st_nx = bad ? ST_ERR : ST_LEAD;
            ST_LEAD:  if (cnt == SETTLE_LAST) st_nx = ST_BYTE;
            ST_BYTE:  if (cnt == byte_last)   st_nx = ST_TERM;
            ST_TERM:  st_nx = ST_TRAIL;
            ST_TRAIL: if (cnt == SETTLE_LAST) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            ST_ERR:   st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Restart the counter whenever a new state begins.
    assign cnt_clr = (st_nx != state) || (state == ST_IDLE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nx;
    end

    AST_TERM_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TERM) |-> ($past(state) == ST_BYTE)); // R7
    AST_LEAD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_LEAD) |-> ($past(state) == ST_IDLE)); // R10
endmodule

// File: rtl/nand_cmd_addr_gen.sv
// NAND command/address cycle generator top.
// Captures one request while idle and plays it out on the flash control lines.
// Assumes: a downstream block owns data transfer and the ready/busy wait.
module nand_cmd_addr_gen
    import nand_cag_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 24,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_addr,
    input  logic [DATA_W-1:0] req_cmd,
    input  logic [1:0]        req_ncyc,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic              req_wp,
    input  logic              req_tail_wp,
    output logic              nand_ce,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_wp,
    output logic [DATA_W-1:0] io_data,
    output logic              io_we,
    output logic              pipe_term,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int CNT_W = $clog2(SETTLE_CYC) + 2;

    cag_state_e        state;
    logic              start, bad, cnt_clr;
    logic [CNT_W-1:0]  cnt;
    logic              is_addr_q, wp_q, tail_q;
    logic [DATA_W-1:0] cmd_q, byte_w;
    logic [1:0]        ncyc_q, nbytes;
    logic [OFS_W-1:0]  ofs_q;
    logic              in_phase, latch_hi;

    assign start  = req_valid && (state == ST_IDLE);
    assign bad    = req_is_addr && (req_ncyc == 2'd0);
    assign nbytes = is_addr_q ? ncyc_q : 2'd1;

    // Capture the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_addr_q <= 1'b0; cmd_q <= '0; ncyc_q <= '0;
            ofs_q <= '0; wp_q <= 1'b0; tail_q <= 1'b0;
        end else if (start) begin
            is_addr_q <= req_is_addr; cmd_q <= req_cmd; ncyc_q <= req_ncyc;
            ofs_q <= req_offset; wp_q <= req_wp; tail_q <= req_tail_wp;
        end
    end

    nand_cag_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(cnt)
    );

    nand_cag_seq #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .bad(bad), .nbytes(nbytes),
        .cnt(cnt), .cnt_clr(cnt_clr), .state(state)
    );

    nand_cag_byte_sel #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_sel (
        .is_addr(is_addr_q), .cmd(cmd_q), .ncyc(ncyc_q), .ofs(ofs_q),
        .idx(cnt[1:0]), .byte_o(byte_w)
    );

    // Decode the flash lines from the phase state.
    always_comb begin
        in_phase  = (state == ST_LEAD) || (state == ST_BYTE) ||
                    (state == ST_TERM) || (state == ST_TRAIL);
        latch_hi  = (state == ST_LEAD) || (state == ST_BYTE) || (state == ST_TERM);
        nand_ce   = in_phase;
        nand_cle  = latch_hi && !is_addr_q;
        nand_ale  = latch_hi && is_addr_q;
        nand_wp   = in_phase && (wp_q || ((state == ST_TRAIL) && is_addr_q && tail_q));
        io_we     = (state == ST_BYTE);
        io_data   = (state == ST_BYTE) ? byte_w : '0;
        pipe_term = (state == ST_TERM);
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        err       = (state == ST_ERR);
    end

    AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R2
    AST_LATCH_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> nand_ce); // R2
    AST_STROBE_UNDER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        io_we |-> ((nand_cle || nand_ale) && $past(nand_cle || nand_ale))); // R3
    AST_TERM_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_term |-> ($past(io_we) && !io_we && (nand_cle || nand_ale))); // R7
    AST_LATCH_FALLS_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_term |=> (!nand_cle && !nand_ale && nand_ce && !pipe_term)); // R7
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!nand_ce && !io_we && !done)); // R9
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !nand_ce)); // R9
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done)); // R10
endmodule

// File: tb/nand_cmd_addr_gen_bench.sv
module nand_cmd_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_is_addr = 1'b0, req_wp = 1'b0, req_tail_wp = 1'b0;
    logic [7:0]  req_cmd = '0;
    logic [1:0]  req_ncyc = '0;
    logic [23:0] req_offset = '0;
    logic        nand_ce, nand_cle, nand_ale, nand_wp, io_we, pipe_term, busy, done, err;
    logic [7:0]  io_data;

    int n_checks = 0;
    int n_errs = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    nand_cmd_addr_gen u_nand_cmd_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_addr(req_is_addr),
        .req_cmd(req_cmd), .req_ncyc(req_ncyc), .req_offset(req_offset),
        .req_wp(req_wp), .req_tail_wp(req_tail_wp),
        .nand_ce(nand_ce), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_wp(nand_wp),
        .io_data(io_data), .io_we(io_we), .pipe_term(pipe_term),
        .busy(busy), .done(done), .err(err)
    );

    // Watchdog: ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_errs = n_errs + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    // Packed output view {ce,cle,ale,wp,we,term,busy,done,err,data}.
    function automatic logic [16:0] pack_out(logic ce, logic cle, logic ale, logic wp,
            logic we, logic tm, logic bz, logic dn, logic er, logic [7:0] d);
        return {ce, cle, ale, wp, we, tm, bz, dn, er, d};
    endfunction

    // Expected address byte from the requirements (R4, R5, R6).
    function automatic logic [7:0] exp_addr_byte(logic [1:0] ncyc, logic [23:0] ofs, int i);
        logic [7:0] lo, mid, hi;
        lo  = ofs[7:0];
        mid = ofs[16:9];
        hi  = {1'b0, ofs[23:17]};
        if (ncyc == 2'd1) return lo;
        if (ncyc == 2'd2) return (i == 0) ? mid : hi;
        return (i == 0) ? lo : ((i == 1) ? mid : hi);
    endfunction

    task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_errs = n_errs + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] sample();
        return pack_out(nand_ce, nand_cle, nand_ale, nand_wp, io_we, pipe_term,
                        busy, done, err, io_data);
    endfunction

    // Issue one request and compare every cycle against the expected trace.
    task automatic run_req(logic is_addr, logic [7:0] cmd, logic [1:0] ncyc,
                           logic [23:0] ofs, logic wp, logic tail, logic poke);
        int nb;
        logic [16:0] e;
        string btag;
        @(negedge clk);
        req_valid = 1'b1; req_is_addr = is_addr; req_cmd = cmd; req_ncyc = ncyc;
        req_offset = ofs; req_wp = wp; req_tail_wp = tail;
        if (is_addr && ncyc == 2'd0) begin
            @(negedge clk); req_valid = 1'b0;
            check("R9 err cycle", sample(), pack_out(0,0,0,0,0,0,1,0,1,8'h00));
            @(negedge clk);
            check("R9 quiet after err", sample(), pack_out(0,0,0,0,0,0,0,0,0,8'h00));
            return;
        end
        nb = is_addr ? int'(ncyc) : 1;
        btag = !is_addr ? "R1 R3 cmd byte" : (ncyc == 2'd1) ? "R4 R3 addr byte" :
               (ncyc == 2'd2) ? "R5 R3 addr byte" : "R6 R3 addr byte";
        for (int k = 1; k <= 11 + nb; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (poke && k == 3) begin
                req_valid = 1'b1; req_is_addr = ~is_addr; req_cmd = ~cmd;
                req_ncyc = 2'd3; req_offset = ~ofs; req_wp = ~wp; req_tail_wp = 1'b1;
            end
            if (poke && k == 4) req_valid = 1'b0;
            if (k <= 4) begin
                e = pack_out(1, !is_addr, is_addr, wp, 0, 0, 1, 0, 0, 8'h00);
                check(poke ? "R10 ignored while busy" : (is_addr ? "R2 lead" : "R1 lead"),
                      sample(), e);
            end else if (k <= 4 + nb) begin
                e = pack_out(1, !is_addr, is_addr, wp, 1, 0, 1, 0, 0,
                             is_addr ? exp_addr_byte(ncyc, ofs, k - 5) : cmd);
                check(btag, sample(), e);
            end else if (k == 5 + nb) begin
                e = pack_out(1, !is_addr, is_addr, wp, 0, 1, 1, 0, 0, 8'h00);
                check("R7 terminate", sample(), e);
            end else if (k <= 9 + nb) begin
                e = pack_out(1, 0, 0, wp | (is_addr & tail), 0, 0, 1, 0, 0, 8'h00);
                check("R8 trail", sample(), e);
            end else if (k == 10 + nb) begin
                check("R10 done", sample(), pack_out(0,0,0,0,0,0,1,1,0,8'h00));
            end else begin
                check("R10 idle", sample(), pack_out(0,0,0,0,0,0,0,0,0,8'h00));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset state", sample(), pack_out(0,0,0,0,0,0,0,0,0,8'h00));
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", sample(), pack_out(0,0,0,0,0,0,0,0,0,8'h00));

        // Directed corner cases.
        run_req(1'b0, 8'hFF, 2'd0, 24'h0, 1'b1, 1'b0, 1'b0);          // R1 command
        run_req(1'b0, 8'h00, 2'd3, 24'hFFFFFF, 1'b0, 1'b1, 1'b0);     // R8 no tail on command
        run_req(1'b1, 8'h00, 2'd1, 24'hABCDEF, 1'b1, 1'b0, 1'b0);     // R4
        run_req(1'b1, 8'h00, 2'd2, 24'h5A5A5A, 1'b0, 1'b1, 1'b0);     // R5 R8 tail
        run_req(1'b1, 8'h00, 2'd3, 24'h000100, 1'b0, 1'b0, 1'b0);     // R6 bit 8 only
        run_req(1'b1, 8'h00, 2'd3, 24'hFFFFFF, 1'b1, 1'b1, 1'b0);     // R6 all ones
        run_req(1'b1, 8'h00, 2'd0, 24'h123456, 1'b1, 1'b1, 1'b0);     // R9
        run_req(1'b1, 8'h3C, 2'd2, 24'h876543, 1'b0, 1'b0, 1'b1);     // R10 poke while busy
        run_req(1'b0, 8'h70, 2'd0, 24'h0, 1'b0, 1'b0, 1'b1);          // R10 poke on command

        // Constrained random requests.
        for (int i = 0; i < 40; i++) begin
            logic ia;
            logic [1:0] nc;
            ia = 1'($urandom);
            nc = 2'(($urandom % 3) + 1);
            if (($urandom % 10) == 0) nc = 2'd0;
            run_req(ia, 8'($urandom), ia ? nc : 2'd1, 24'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
        end

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule